// File: doc/BRIEF.md
# Chordal Ring Next-Hop Router

This block computes, in one combinational step, where a flit goes next inside a ring network of 4·N switches. Each switch has four ports: a local port to its attached IP, a clockwise link, a counterclockwise link, and a chord link to the switch directly opposite on the ring. Every port has an input side and an output side, so a position in the network is the triple (node id, port, side).

A flit sitting on an input side moves first to an output side of the same switch. The output it takes depends on the destination's offset around the ring from the current switch: zero means local delivery, a small positive offset goes clockwise, an offset near a full turn goes counterclockwise, and anything in between takes the chord. A flit sitting on an output side then crosses its link into the facing input of the neighbour. A flit on the local output has arrived, and its route ends there.

The flit handshake is valid/ready and passes straight through the block. The upstream holder offers a position with `hop_vld`. The block presents the next position on `nxt_vld`, and `hop_rdy` follows `nxt_rdy`, so back-pressure from the next stage stalls the current holder. A flit on the local output has no next position: `nxt_vld` stays low, `hop_rdy` is high, and the flit is consumed.

Top module: `chordal_next_hop`

## Requirements
- R1: The ring offset is (destination − current) mod 4·N. Every routing decision on an input side follows from this offset.
- R2: On an input side with offset 0, the next position is the same node's local port, output side. Encoding: port local=0, cw=1, ccw=2, chord=3; side input=0, output=1.
- R3: On an input side with offset 1..N, the next position is the same node's cw port, output side.
- R4: On an input side with offset 3·N..4·N−1, the next position is the same node's ccw port, output side.
- R5: On an input side with offset N+1..3·N−1, the next position is the same node's chord port, output side.
- R6: On the cw output of node k, the next position is the ccw input of node (k+1) mod 4·N.
- R7: On the ccw output of node k, the next position is the cw input of node (k−1) mod 4·N.
- R8: On the chord output of node k, the next position is the chord input of node (k+2·N) mod 4·N.
- R9: On the local output, `nxt_vld` is 0 and all next-position fields are 0. On any output side, the destination id has no effect on the result.
- R10: When `hop_vld` is 0, `nxt_vld` is 0 and all next-position fields are 0.
- R11: `hop_rdy` equals `nxt_rdy`, except on the local output, where `hop_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hop_vld | input | 1 | A flit position is offered |
| hop_rdy | output | 1 | The offered flit may advance this cycle |
| cur_node | input | $clog2(4·N) | Node id of the current position |
| cur_port | input | 2 | Port of the current position |
| cur_side | input | 1 | Side of the current position (0 input, 1 output) |
| dst_node | input | $clog2(4·N) | Destination node id |
| nxt_vld | output | 1 | A next position is presented |
| nxt_rdy | input | 1 | The next stage accepts the flit |
| nxt_node | output | $clog2(4·N) | Node id of the next position |
| nxt_port | output | 2 | Port of the next position |
| nxt_side | output | 1 | Side of the next position |

## Verification
The bench targets the region edges at offsets N, N+1, 3·N−1 and 3·N. A wrong comparison there sends a flit the long way around or onto the chord when a ring step is shorter. It exercises id wrap in both directions: a cw hop from the top id, a ccw hop from id 0, and chord hops from the upper half. A modulo slip there produces an out-of-range id or the wrong neighbour. It follows complete routes, including the 2→12 walk on a 16-node ring (chord, cw, cw, local). It also checks that the destination is ignored on output sides and that the local output ends the route with ready high. A block that kept routing on the local output would loop a delivered flit.

// File: rtl/ring_route_pkg.sv
package ring_route_pkg;
  typedef enum logic [1:0] {
    PORT_LOC = 2'd0,
    PORT_CW  = 2'd1,
    PORT_CCW = 2'd2,
    PORT_ACR = 2'd3
  } port_e;

  typedef enum logic {
    SIDE_IN  = 1'b0,
    SIDE_OUT = 1'b1
  } side_e;
endpackage

// File: rtl/ring_reladdr.sv
module ring_reladdr #(
  parameter int N = 4
) (
  input  logic [$clog2(4*N)-1:0] cur,
  input  logic [$clog2(4*N)-1:0] dst,
  output logic [$clog2(4*N)-1:0] rel
);
  localparam int NODES = 4 * N;
  localparam int IDW   = $clog2(NODES);
  localparam logic [IDW:0] NODES_W = NODES[IDW:0];

  logic [IDW:0] diff;
  assign diff = {1'b0, dst} - {1'b0, cur};

  generate
    if (NODES == (1 << IDW)) begin : g_pow2
      assign rel = diff[IDW-1:0];
    end else begin : g_fold
      logic [IDW:0] wrapped;
      assign wrapped = diff[IDW] ? (diff + NODES_W) : diff;
      assign rel = wrapped[IDW-1:0];
    end
  endgenerate

  logic [IDW:0] chk_sum;
  logic [IDW:0] chk_back;
  always_comb begin
    chk_sum  = {1'b0, cur} + {1'b0, rel};
    chk_back = (chk_sum >= NODES_W) ? (chk_sum - NODES_W) : chk_sum;
    if (cur < NODES_W[IDW-1:0] || NODES == (1 << IDW)) begin
      if (dst < NODES_W[IDW-1:0] || NODES == (1 << IDW)) begin
        a_r1_offset_reaches_dest: assert (chk_back[IDW-1:0] == dst);
      end
    end
  end
endmodule

// File: rtl/ring_dir_sel.sv
module ring_dir_sel
  import ring_route_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [$clog2(4*N)-1:0] rel,
  output port_e                  pick
);
  localparam int IDW = $clog2(4 * N);
  localparam logic [IDW:0] CW_MAX  = N[IDW:0];
  localparam logic [IDW:0] CCW_MIN = 3 * N;

  logic [IDW:0] rel_w;
  assign rel_w = {1'b0, rel};

  always_comb begin
    if (rel_w == '0)            pick = PORT_LOC;
    else if (rel_w <= CW_MAX)   pick = PORT_CW;
    else if (rel_w >= CCW_MIN)  pick = PORT_CCW;
    else                        pick = PORT_ACR;
  end
endmodule

// File: rtl/ring_link_map.sv
module ring_link_map
  import ring_route_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [$clog2(4*N)-1:0] node,
  input  port_e                  port,
  output logic [$clog2(4*N)-1:0] nbr_node,
  output port_e                  nbr_port,
  output logic                   ends
);
  localparam int NODES = 4 * N;
  localparam int IDW   = $clog2(NODES);
  localparam logic [IDW:0] NODES_W = NODES[IDW:0];
  localparam logic [IDW:0] HALF_W  = (2 * N);

  logic [IDW-1:0] up_id;
  logic [IDW-1:0] dn_id;
  logic [IDW-1:0] op_id;

  generate
    if (NODES == (1 << IDW)) begin : g_pow2
      logic [IDW:0] op_sum;
      assign up_id  = node + 1'b1;
      assign dn_id  = node - 1'b1;
      assign op_sum = {1'b0, node} + HALF_W;
      assign op_id  = op_sum[IDW-1:0];
    end else begin : g_fold
      logic [IDW:0] up_sum;
      logic [IDW:0] op_sum;
      logic [IDW:0] op_fix;
      assign up_sum = {1'b0, node} + 1'b1;
      assign up_id  = (up_sum == NODES_W) ? '0 : up_sum[IDW-1:0];
      assign dn_id  = (node == '0) ? (NODES_W[IDW-1:0] - 1'b1) : (node - 1'b1);
      assign op_sum = {1'b0, node} + HALF_W;
      assign op_fix = (op_sum >= NODES_W) ? (op_sum - NODES_W) : op_sum;
      assign op_id  = op_fix[IDW-1:0];
    end
  endgenerate

  always_comb begin
    ends     = 1'b0;
    nbr_node = '0;
    nbr_port = PORT_LOC;
    unique case (port)
      PORT_CW:  begin nbr_node = up_id; nbr_port = PORT_CCW; end
      PORT_CCW: begin nbr_node = dn_id; nbr_port = PORT_CW;  end
      PORT_ACR: begin nbr_node = op_id; nbr_port = PORT_ACR; end
      default:  ends = 1'b1;
    endcase
  end

  always_comb begin
    if (port == PORT_ACR) begin
      a_r8_chord_is_involution: assert (
        ((({1'b0, nbr_node} + HALF_W) >= NODES_W) ?
          (({1'b0, nbr_node} + HALF_W) - NODES_W) :
          ({1'b0, nbr_node} + HALF_W)) == {1'b0, node});
    end
  end
endmodule

// File: rtl/chordal_next_hop.sv
module chordal_next_hop
  import ring_route_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                   hop_vld,
  output logic                   hop_rdy,
  input  logic [$clog2(4*N)-1:0] cur_node,
  input  logic [1:0]             cur_port,
  input  logic                   cur_side,
  input  logic [$clog2(4*N)-1:0] dst_node,
  output logic                   nxt_vld,
  input  logic                   nxt_rdy,
  output logic [$clog2(4*N)-1:0] nxt_node,
  output logic [1:0]             nxt_port,
  output logic                   nxt_side
);
  localparam int IDW = $clog2(4 * N);

  logic [IDW-1:0] rel;
  port_e          pick;
  port_e          here_port;
  logic [IDW-1:0] link_node;
  port_e          link_port;
  logic           link_ends;
  logic           route_ends;

  assign here_port = port_e'(cur_port);

  ring_reladdr #(.N(N)) u_rel (
    .cur (cur_node),
    .dst (dst_node),
    .rel (rel)
  );

  ring_dir_sel #(.N(N)) u_sel (
    .rel  (rel),
    .pick (pick)
  );

  ring_link_map #(.N(N)) u_link (
    .node     (cur_node),
    .port     (here_port),
    .nbr_node (link_node),
    .nbr_port (link_port),
    .ends     (link_ends)
  );

  assign route_ends = (cur_side == SIDE_OUT) && link_ends;
  assign hop_rdy    = route_ends ? 1'b1 : nxt_rdy;

  always_comb begin
    nxt_vld  = 1'b0;
    nxt_node = '0;
    nxt_port = '0;
    nxt_side = 1'b0;
    if (hop_vld && !route_ends) begin
      nxt_vld = 1'b1;
      if (cur_side == SIDE_IN) begin
        nxt_node = cur_node;
        nxt_port = pick;
        nxt_side = SIDE_OUT;
      end else begin
        nxt_node = link_node;
        nxt_port = link_port;
        nxt_side = SIDE_IN;
      end
    end
  end

  always_comb begin
    if (hop_vld && cur_side == SIDE_IN) begin
      a_r2_inside_switch_step: assert (nxt_vld && nxt_node == cur_node && nxt_side == SIDE_OUT);
    end
    if (hop_vld && cur_side == SIDE_OUT && here_port != PORT_LOC) begin
      a_r6_link_step_leaves_node: assert (nxt_vld && nxt_node != cur_node && nxt_side == SIDE_IN);
    end
    if (cur_side == SIDE_OUT && here_port == PORT_LOC) begin
      a_r9_local_output_ends: assert (!nxt_vld && hop_rdy);
    end
    if (!hop_vld) begin
      a_r10_idle_outputs_quiet: assert (!nxt_vld && nxt_node == '0 && nxt_port == '0);
    end
    if (!(cur_side == SIDE_OUT && here_port == PORT_LOC)) begin
      a_r11_ready_passthrough: assert (hop_rdy == nxt_rdy);
    end
  end
endmodule

// File: tb/chordal_next_hop_test.sv
module chordal_next_hop_test;
  localparam int N     = 4;
  localparam int NODES = 4 * N;
  localparam int IDW   = $clog2(NODES);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           hop_vld, hop_rdy, nxt_vld, nxt_rdy, cur_side, nxt_side;
  logic [IDW-1:0] cur_node, dst_node, nxt_node;
  logic [1:0]     cur_port, nxt_port;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  chordal_next_hop #(.N(N)) uut (
    .hop_vld(hop_vld), .hop_rdy(hop_rdy), .cur_node(cur_node),
    .cur_port(cur_port), .cur_side(cur_side), .dst_node(dst_node),
    .nxt_vld(nxt_vld), .nxt_rdy(nxt_rdy), .nxt_node(nxt_node),
    .nxt_port(nxt_port), .nxt_side(nxt_side)
  );

  function automatic int offs(int c, int d);
    return ((d - c) % NODES + NODES) % NODES;
  endfunction

  function automatic int pick_port(int r);
    if (r == 0) return 0;
    if (r <= N) return 1;
    if (r >= 3 * N) return 2;
    return 3;
  endfunction

  // expected {vld, node, port, side}
  function automatic logic [IDW+3:0] expect_hop(bit v, int c, int p, bit s, int d);
    int en, ep;
    if (!v) return '0;
    if (!s) begin
      ep = pick_port(offs(c, d));
      return {1'b1, IDW'(c), 2'(ep), 1'b1};
    end
    case (p)
      1: begin en = (c + 1) % NODES;         ep = 2; end
      2: begin en = (c + NODES - 1) % NODES; ep = 1; end
      3: begin en = (c + 2 * N) % NODES;     ep = 3; end
      default: return '0;
    endcase
    return {1'b1, IDW'(en), 2'(ep), 1'b0};
  endfunction

  task automatic drive(bit v, int c, int p, bit s, int d, bit r);
    @(negedge clk);
    hop_vld = v; cur_node = IDW'(c); cur_port = 2'(p);
    cur_side = s; dst_node = IDW'(d); nxt_rdy = r;
    #1;
  endtask

  task automatic check_hop(string req, bit v, int c, int p, bit s, int d, bit r);
    logic [IDW+3:0] exp_v, got_v;
    bit exp_r;
    drive(v, c, p, s, d, r);
    exp_v = expect_hop(v, c, p, s, d);
    exp_r = (s && p == 0) ? 1'b1 : r;
    got_v = {nxt_vld, nxt_node, nxt_port, nxt_side};
    n_chk++;
    if (got_v !== exp_v || hop_rdy !== exp_r) begin
      n_bad++;
      $display("FAIL %s: node=%0d port=%0d side=%0d dst=%0d got vld/node/port/side=%h rdy=%b expected %h rdy=%b",
               req, c, p, s, d, got_v, hop_rdy, exp_v, exp_r);
    end
  endtask

  task automatic walk(string req, int src, int dst, int max_steps);
    int c = src, p = 0, cnt = 0;
    bit s = 0;
    while (!(s && p == 0) && cnt < max_steps) begin
      check_hop(req, 1, c, p, s, dst, 1);
      c = nxt_node; p = nxt_port; s = nxt_side;
      cnt++;
    end
    n_chk++;
    if (c != dst || !(s && p == 0)) begin
      n_bad++;
      $display("FAIL %s: walk %0d->%0d ended at node=%0d port=%0d side=%0d expected node=%0d local output",
               req, src, dst, c, p, s, dst);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int seed_dummy;
    hop_vld = 0; cur_node = '0; cur_port = '0; cur_side = 0; dst_node = '0; nxt_rdy = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    seed_dummy = $urandom(32'h5eed_1234);

    // R10: reset/idle state
    check_hop("R10 idle", 0, 0, 0, 0, 0, 0);
    check_hop("R10 idle busy inputs", 0, 7, 3, 1, 2, 1);
    // R2 local delivery
    check_hop("R2 offset zero", 1, 9, 0, 0, 9, 1);
    // R3/R5 edges N and N+1
    check_hop("R3 offset N", 1, 5, 2, 0, 5 + N, 1);
    check_hop("R3 offset 1 wrap", 1, NODES - 1, 0, 0, 0, 1);
    check_hop("R5 offset N+1", 1, 5, 1, 0, (5 + N + 1) % NODES, 1);
    check_hop("R5 offset 3N-1", 1, 0, 0, 0, 3 * N - 1, 1);
    // R4 edges
    check_hop("R4 offset 3N", 1, 0, 0, 0, 3 * N, 1);
    check_hop("R4 offset 4N-1", 1, 3, 0, 0, 2, 1);
    // R6/R7/R8 wrap
    check_hop("R6 cw wrap", 1, NODES - 1, 1, 1, 4, 1);
    check_hop("R7 ccw wrap", 1, 0, 2, 1, 4, 1);
    check_hop("R8 chord upper half", 1, NODES - 1, 3, 1, 0, 1);
    check_hop("R8 chord lower half", 1, 1, 3, 1, 0, 1);
    // R9 terminate, destination ignored on output side
    check_hop("R9 local output", 1, 6, 0, 1, 3, 0);
    check_hop("R9 dst ignored a", 1, 6, 1, 1, 0, 1);
    check_hop("R9 dst ignored b", 1, 6, 1, 1, 13, 1);
    // R11 back-pressure
    check_hop("R11 stall", 1, 4, 3, 1, 1, 0);
    check_hop("R11 stall input side", 1, 4, 0, 0, 11, 0);
    // R1 route walks, including 2 -> 12
    walk("R1 R5 walk 2 to 12", 2, 12, 4 * N);
    walk("R1 walk 0 to 15", 0, 15, 4 * N);
    walk("R1 walk 7 to 7", 7, 7, 4 * N);

    for (int i = 0; i < 3000; i++) begin
      check_hop("R1-group random", $urandom_range(0, 9) != 0, $urandom_range(0, NODES - 1),
                $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, NODES - 1),
                $urandom_range(0, 1));
    end
    for (int i = 0; i < 200; i++) begin
      walk("R1 random walk", $urandom_range(0, NODES - 1), $urandom_range(0, NODES - 1), 4 * N);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule